// File: doc/BRIEF.md
# Match-Compare Operating-System Timer

This block is a free-running 32-bit count register with four 32-bit compare channels, a sticky event register, a per-channel interrupt gate and a watchdog arm register, all reached through a simple single-cycle register bus. The count advances by one on every cycle in which the tick-enable input is high. That input stands for the base timer clock, which runs at 3.6864 MHz, so each count is one pulse. Clock generation lives outside this block.

The tick that produces a new count also compares it with every compare channel. When it equals channel n and that channel's gate bit is set, event bit n becomes set and interrupt line n goes high. The line stays high until software clears the bit by writing a one to it. Channel 3 also serves as a watchdog. If it matches while the watchdog arm bit is set, the block issues a one-cycle reset request and disarms itself.

Top module: `ostmr_core`

## Requirements
- R1: After a synchronous reset the count, the event register, the interrupt gate, the watchdog arm register and every compare value read 0. The interrupt lines and the reset request are low.
- R2: Each cycle with `tick_en` high adds one to the count, and a cycle without it leaves the count unchanged. The count wraps from 0xFFFFFFFF to 0.
- R3: A bus write to offset 0x10 loads the count at the next edge, and counting then continues from the loaded value. If a tick arrives in the same cycle, the load wins.
- R4: When a tick produces a count equal to compare channel n, and gate bit n (bit n of offset 0x1C) is 1, event bit n (bit n of offset 0x14) and `irq[n]` are high from that edge on. A count that arrives by a bus load does not trigger a match.
- R5: A channel whose gate bit is 0 sets no event bit and raises no interrupt when it matches.
- R6: Writing offset 0x14 clears each event bit that is 1 both in the written value and in the register, and lowers the matching `irq` line. Written zeros leave bits alone, and a written one never sets a bit.
- R7: The interrupt gate at offset 0x1C stores only bits 11:0 of a write. Bits 31:12 read back as 0.
- R8: When channel 3 matches while bit 0 of the watchdog arm register (offset 0x18) is 1, `wdt_req` is high for exactly one cycle and the arm register clears to 0. This happens whatever gate bit 3 holds.
- R9: When bit 0 of the arm register is 0, a channel 3 match produces no reset request and the arm register keeps its value.
- R10: A read from an offset outside the map returns 0, and a write to one changes no register.
- R11: The compare channels 0 to 3 are readable and writable at offsets 0x00, 0x04, 0x08 and 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One pulse per base-clock count |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 4 | Per-channel interrupt lines, high while the event bit is set |
| wdt_req | output | 1 | One-cycle system reset request |

## Verification
Compare and event state are held in registers, so a wrong internal value shows at the ports no later than the next matching tick. A compare value that is wrong, or a gate that is wrong, gives an `irq` edge that is missing or extra in the very cycle after the tick that should have matched. A count that has gone wrong reads back wrong at once on offset 0x10. A watchdog arm register that is stuck shows either as a second `wdt_req` pulse on a later match or as a nonzero readback straight after the pulse. Event-clear errors show on the `irq` lines in the cycle after the write.

// File: rtl/ostmr_pkg.sv
// Shared register offsets for the match-compare timer.
// Assumes byte offsets with word-aligned registers.
package ostmr_pkg;
    localparam int OFS_MATCH_BASE = 'h00;
    localparam int MATCH_STRIDE   = 4;
    localparam int OFS_COUNT      = 'h10;
    localparam int OFS_STATUS     = 'h14;
    localparam int OFS_WDOG       = 'h18;
    localparam int OFS_GATE       = 'h1C;

    // One-hot selection of the scalar registers.
    typedef struct packed {
        logic count;
        logic status;
        logic wdog;
        logic gate;
    } reg_sel_t;
endpackage

// File: rtl/ostmr_counter.sv
// Free-running up counter with a bus load port.
// A load takes priority over a tick in the same cycle. The counter wraps naturally.
module ostmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic [W-1:0] next_count,
    output logic         advance
);
    // Next value and the qualifying tick.
    always_comb begin
        next_count = count + W'(1);
        advance    = tick_en && !load;
    end

    // Count register: reset, load or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (load)    count <= load_val;
        else if (tick_en) count <= next_count;
    end
endmodule

// File: rtl/ostmr_match_chan.sv
// One compare channel: holds a compare value and flags equality with the
// count that a tick is about to produce. A load never produces a hit.
module ostmr_match_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         advance,
    input  logic [W-1:0] next_count,
    output logic [W-1:0] value,
    output logic         hit
);
    // Compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= '0;
        else if (wr) value <= wdata;
    end

    // Exact equality, only on a counting tick.
    always_comb hit = advance && (next_count == value);
endmodule

// File: rtl/ostmr_core.sv
// Match-compare timer top level: register decode, event register with
// write-one-to-clear, interrupt gate and watchdog on the last channel.
// Assumes 2 <= N_CH <= 4, so the compare channels fit below the count offset,
// and N_CH <= GATE_W.
module ostmr_core #(
    parameter int DATA_W = 32,
    parameter int N_CH   = 4,
    parameter int GATE_W = 12,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CH-1:0]   irq,
    output logic              wdt_req
);
    import ostmr_pkg::*;

    localparam int WDOG_CH = N_CH - 1;

    reg_sel_t            sel;
    logic [N_CH-1:0]     sel_match;
    logic [N_CH-1:0]     hits;
    logic [DATA_W-1:0]   match_val [N_CH];
    logic [DATA_W-1:0]   count;
    logic [DATA_W-1:0]   next_count;
    logic                advance;
    logic [N_CH-1:0]     status_q;
    logic [N_CH-1:0]     sts_clr;
    logic [GATE_W-1:0]   gate_q;
    logic [DATA_W-1:0]   wdog_q;
    logic                wdt_req_q;

    // Scalar register decode.
    always_comb begin
        sel.count  = bus_addr == ADDR_W'(OFS_COUNT);
        sel.status = bus_addr == ADDR_W'(OFS_STATUS);
        sel.wdog   = bus_addr == ADDR_W'(OFS_WDOG);
        sel.gate   = bus_addr == ADDR_W'(OFS_GATE);
    end

    ostmr_counter #(.W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .load       (bus_wr && sel.count),
        .load_val   (bus_wdata),
        .count      (count),
        .next_count (next_count),
        .advance    (advance)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        // Compare channel decode.
        assign sel_match[i] = bus_addr == ADDR_W'(OFS_MATCH_BASE + MATCH_STRIDE * i);

        ostmr_match_chan #(.W(DATA_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (bus_wr && sel_match[i]),
            .wdata      (bus_wdata),
            .advance    (advance),
            .next_count (next_count),
            .value      (match_val[i]),
            .hit        (hits[i])
        );
    end

    // Bits to clear: only those already set.
    always_comb sts_clr = (bus_wr && sel.status) ? (bus_wdata[N_CH-1:0] & status_q) : '0;

    // Event register: gated set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~sts_clr) | (hits & gate_q[N_CH-1:0]);
    end

    // Interrupt gate keeps only its low bits.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= '0;
        else if (bus_wr && sel.gate) gate_q <= bus_wdata[GATE_W-1:0];
    end

    // Watchdog: a match on the last channel while armed pulses the request and disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdog_q    <= '0;
            wdt_req_q <= 1'b0;
        end else if (hits[WDOG_CH] && wdog_q[0]) begin
            wdog_q    <= '0;
            wdt_req_q <= 1'b1;
        end else begin
            wdt_req_q <= 1'b0;
            if (bus_wr && sel.wdog) wdog_q <= bus_wdata;
        end
    end

    // Read-data multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (sel.count)  bus_rdata = count;
        if (sel.status) bus_rdata = DATA_W'(status_q);
        if (sel.wdog)   bus_rdata = wdog_q;
        if (sel.gate)   bus_rdata = DATA_W'(gate_q);
        for (int i = 0; i < N_CH; i++)
            if (sel_match[i]) bus_rdata = match_val[i];
    end

    assign irq     = status_q;
    assign wdt_req = wdt_req_q;
endmodule

// File: rtl/ostmr_core_chk.sv
// Property checker for ostmr_core, attached by bind. It watches the bus, the
// outputs and the count, gate and watchdog registers.
module ostmr_core_chk #(
    parameter int DATA_W = 32,
    parameter int N_CH   = 4,
    parameter int GATE_W = 12,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [N_CH-1:0]   irq,
    input logic              wdt_req,
    input logic [DATA_W-1:0] count,
    input logic [GATE_W-1:0] gate_q,
    input logic [DATA_W-1:0] wdog_q
);
    import ostmr_pkg::*;

    logic armed;
    logic cnt_wr;

    // Becomes 1 one cycle after reset is released, so $past never sees pre-reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    always_comb cnt_wr = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(tick_en && !cnt_wr) |-> count == $past(count) + DATA_W'(1));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!tick_en && !cnt_wr) |-> count == $past(count));

    p_count_load_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(cnt_wr) |-> count == $past(bus_wdata));

    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((irq & ~$past(irq)) & ~$past(gate_q[N_CH-1:0])) == '0);

    p_irq_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (irq & ~$past(irq)) != '0 |-> $past(tick_en && !cnt_wr));

    p_wdt_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req |=> !wdt_req);

    p_wdt_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req |-> wdog_q == '0);

    p_wdt_armed_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        wdt_req |-> $past(wdog_q[0]));
endmodule

bind ostmr_core ostmr_core_chk #(
    .DATA_W (DATA_W),
    .N_CH   (N_CH),
    .GATE_W (GATE_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .wdt_req   (wdt_req),
    .count     (count),
    .gate_q    (gate_q),
    .wdog_q    (wdog_q)
);

// File: tb/ostmr_core_bench.sv
// Directed bench for ostmr_core: one task per scenario, each checking its results.
module ostmr_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        wdt_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [7:0] A_M0 = 8'h00, A_M1 = 8'h04, A_M2 = 8'h08, A_M3 = 8'h0C;
    localparam logic [7:0] A_CNT = 8'h10, A_STS = 8'h14, A_WDG = 8'h18, A_GATE = 8'h1C;

    always #10 clk = ~clk;

    ostmr_core u_ostmr_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .wdt_req   (wdt_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CNT, v);  check("R1 count", v, 0);
        rd(A_STS, v);  check("R1 status", v, 0);
        rd(A_GATE, v); check("R1 gate", v, 0);
        rd(A_WDG, v);  check("R1 watchdog arm", v, 0);
        rd(A_M3, v);   check("R1 compare3", v, 0);
        check("R1 irq", {28'd0, irq}, 0);
        check("R1 wdt_req", {31'd0, wdt_req}, 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        ticks(5);
        rd(A_CNT, v); check("R2 five ticks", v, 5);
        repeat (4) @(negedge clk);
        rd(A_CNT, v); check("R2 hold without tick", v, 5);
        wr(A_CNT, 32'hFFFF_FFFE);
        ticks(3);
        rd(A_CNT, v); check("R2 wrap", v, 1);
    endtask

    task automatic t_load();
        logic [31:0] v;
        wr(A_CNT, 32'h100);
        rd(A_CNT, v); check("R3 load", v, 32'h100);
        ticks(3);
        rd(A_CNT, v); check("R3 continue after load", v, 32'h103);
        @(negedge clk);
        tick_en = 1'b1; bus_addr = A_CNT; bus_wdata = 32'h50; bus_wr = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0;
        rd(A_CNT, v); check("R3 load beats tick", v, 32'h50);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(A_M0, 32'h1111_0000); wr(A_M1, 32'h2222_0001);
        wr(A_M2, 32'h3333_0002); wr(A_M3, 32'h4444_0003);
        rd(A_M0, v); check("R11 compare0", v, 32'h1111_0000);
        rd(A_M1, v); check("R11 compare1", v, 32'h2222_0001);
        rd(A_M2, v); check("R11 compare2", v, 32'h3333_0002);
        rd(A_M3, v); check("R11 compare3", v, 32'h4444_0003);
        wr(A_GATE, 32'hFFFF_FFFF);
        rd(A_GATE, v); check("R7 gate width", v, 32'h0000_0FFF);
    endtask

    task automatic t_match();
        logic [31:0] v;
        wr(A_GATE, 32'h5);
        wr(A_M0, 32'h200); wr(A_M1, 32'h201); wr(A_M2, 32'h202); wr(A_M3, 32'h0);
        wr(A_CNT, 32'h1FF);
        ticks(1);
        check("R4 irq ch0", {28'd0, irq}, 32'h1);
        ticks(1);
        check("R5 disabled ch1", {28'd0, irq}, 32'h1);
        ticks(1);
        rd(A_STS, v); check("R4 status ch0+ch2", v, 32'h5);
        wr(A_STS, 32'hA);
        rd(A_STS, v); check("R6 write one to clear bit never sets", v, 32'h5);
        wr(A_STS, 32'h1);
        check("R6 irq after clear", {28'd0, irq}, 32'h4);
        wr(A_STS, 32'hF);
        rd(A_STS, v); check("R6 clear all", v, 0);
        wr(A_CNT, 32'h200);
        rd(A_STS, v); check("R4 load does not match", v, 0);
    endtask

    task automatic t_wdog();
        logic [31:0] v;
        wr(A_GATE, 32'h0);
        wr(A_M3, 32'h300);
        wr(A_WDG, 32'h1);
        wr(A_CNT, 32'h2FF);
        ticks(1);
        check("R8 reset pulse", {31'd0, wdt_req}, 1);
        @(negedge clk);
        check("R8 pulse one cycle", {31'd0, wdt_req}, 0);
        rd(A_WDG, v); check("R8 arm cleared", v, 0);
        rd(A_STS, v); check("R5 gate3 off no status", v, 0);
        wr(A_WDG, 32'h2);
        wr(A_CNT, 32'h2FF);
        ticks(1);
        check("R9 no pulse when disarmed", {31'd0, wdt_req}, 0);
        rd(A_WDG, v); check("R9 arm value kept", v, 32'h2);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(A_CNT, 32'h77);
        wr(A_M0, 32'h88);
        wr(8'h20, 32'hDEAD_BEEF);
        wr(8'h01, 32'hCAFE_0000);
        rd(8'h20, v); check("R10 unmapped read 0x20", v, 0);
        rd(8'h01, v); check("R10 unaligned read", v, 0);
        rd(A_CNT, v); check("R10 count untouched", v, 32'h77);
        rd(A_M0, v);  check("R10 compare0 untouched", v, 32'h88);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_load();
        t_map();
        t_match();
        t_wdog();
        t_unmapped();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule